// File: doc/BRIEF.md
# Keyed Configuration Register Gate

This block guards a small indexed configuration register file behind a four-byte unlock key. It sits on a byte-wide I/O bus and answers at two adjacent addresses: an index port at a base address and a data port at the base plus one. A strap input picks one of two base addresses. While the block is locked, the bytes written to the index port go to a key matcher. Once the correct key has arrived, the host writes a register number to the index port and then reads or writes that register through the data port.

The global registers are a two-byte chip identifier, a revision byte, a logical-device selector and an exit register. A window of device registers shows the store of whichever logical device the selector names. The final key byte depends on which base address is strapped. Leaving configuration mode is done by writing a command value to the exit register, not by sending a key.

Top module: `cfg_key_gate`

## Requirements
- R1: After reset the block is locked, and reads of both its index port and its data port return 0xFF.
- R2: With `base_sel`=0 (base 0x2E), writing 0x87, 0x01, 0x55, 0x55 to address 0x2E unlocks the block from the next cycle onward.
- R3: With `base_sel`=1 (base 0x4E), the fourth key byte must be 0xAA. A fourth byte of 0x55 at base 0x4E leaves the block locked, and 0xAA at base 0x2E also leaves it locked.
- R4: A key byte that does not match sends the matcher back to idle. A byte of 0x87 always restarts the match as the first byte, so 0x87 0x87 0x01 0x55 0x55 unlocks, and 0x87 0x01 0x00 0x55 0x55 does not.
- R5: While locked, data-port writes change no register.
- R6: While unlocked, an index-port write latches the index byte, and an index-port read returns it.
- R7: Index 0x20 reads the high byte of `CHIP_ID`, index 0x21 reads the low byte, and index 0x22 reads `CHIP_REV`. Writes to these indices have no effect.
- R8: Index 0x07 holds the logical-device selector and reads back the value written. Indices 0x30 to 0x30+`DEV_REGS`-1 access the register store of the selected device, and each device has its own store. For a selector value of `NUM_DEV` or above, writes are dropped and reads return 0x00.
- R9: Writing 0x02 to index 0x02 locks the block. Any other value written to index 0x02 leaves it unlocked.
- R10: Reads of any address other than the active index and data ports return 0xFF, and writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_sel | input | 1 | Strap: 0 selects base 0x2E, 1 selects base 0x4E |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe (read data is presented combinationally) |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port |

## Verification
A matcher that is stuck in the wrong step shows up as a correct key failing to unlock, or a corrupted key unlocking. This is visible on the first read after the fourth key byte, because locked reads return 0xFF. A stale index or selector shows up as the wrong byte on the very next data-port read. A device bank that aliases another is caught by writing distinct values to two banks and reading both back. An exit that fails to lock leaves the index port readable one cycle after the exit write.

// File: rtl/cfg_gate_pkg.sv
// Package: key bytes, global register indices and matcher step encoding
// for the keyed configuration gate. Assumes byte-wide data.
package cfg_gate_pkg;
    localparam logic [7:0] KEY_B0     = 8'h87;
    localparam logic [7:0] KEY_B1     = 8'h01;
    localparam logic [7:0] KEY_B2     = 8'h55;
    localparam logic [7:0] KEY_LAST_L = 8'h55;
    localparam logic [7:0] KEY_LAST_H = 8'hAA;

    localparam logic [7:0] IX_EXIT    = 8'h02;
    localparam logic [7:0] IX_DEVSEL  = 8'h07;
    localparam logic [7:0] IX_ID_HI   = 8'h20;
    localparam logic [7:0] IX_ID_LO   = 8'h21;
    localparam logic [7:0] IX_REV     = 8'h22;
    localparam logic [7:0] IX_DEV0    = 8'h30;
    localparam logic [7:0] EXIT_CMD   = 8'h02;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_GOT1 = 2'd1,
        KS_GOT2 = 2'd2,
        KS_GOT3 = 2'd3
    } key_step_e;
endpackage

// File: rtl/cfg_key_match.sv
// Module: cfg_key_match
// Tracks progress through the four-byte unlock key and holds the lock state.
// Assumes key_we is only asserted while locked; exit_req only while unlocked.
module cfg_key_match
    import cfg_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_we,
    input  logic [7:0] key_byte,
    input  logic [7:0] key_last,
    input  logic       exit_req,
    output logic       unlocked
);
    key_step_e  step;
    logic [7:0] want;

    // Byte expected at the current step
    always_comb begin
        case (step)
            KS_IDLE: want = KEY_B0;
            KS_GOT1: want = KEY_B1;
            KS_GOT2: want = KEY_B2;
            default: want = key_last;
        endcase
    end

    // Step and lock state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= KS_IDLE;
            unlocked <= 1'b0;
        end else if (unlocked) begin
            step <= KS_IDLE;
            if (exit_req) unlocked <= 1'b0;
        end else if (key_we) begin
            if (key_byte == want) begin
                case (step)
                    KS_IDLE: step <= KS_GOT1;
                    KS_GOT1: step <= KS_GOT2;
                    KS_GOT2: step <= KS_GOT3;
                    default: begin
                        step     <= KS_IDLE;
                        unlocked <= 1'b1;
                    end
                endcase
            end else if (key_byte == KEY_B0) begin
                step <= KS_GOT1;
            end else begin
                step <= KS_IDLE;
            end
        end
    end

    AST_KEY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && key_we && key_byte == KEY_B0) |=> (step == KS_GOT1)); // R4
    AST_UNLOCK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(step == KS_GOT3 && key_we && key_byte == key_last)); // R2
    AST_IDLE_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |-> (step == KS_IDLE)); // R4
    AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && exit_req) |=> !unlocked); // R9
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// Index latch, global registers and per-device register stores.
// Assumes DEV_REGS is a power of two no greater than 16, so the device
// window starting at 0x30 is aligned, and NUM_DEV is a power of two >= 2.
module cfg_reg_bank
    import cfg_gate_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'h8716,
    parameter logic [7:0]  CHIP_REV = 8'h02,
    parameter int          NUM_DEV  = 4,
    parameter int          DEV_REGS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unlocked,
    input  logic       idx_we,
    input  logic       dat_we,
    input  logic [7:0] wdata,
    output logic [7:0] idx_q,
    output logic [7:0] dat_rdata,
    output logic       exit_req
);
    localparam int         REG_W   = $clog2(DEV_REGS);
    localparam int         DEV_W   = $clog2(NUM_DEV);
    localparam int         TAG_W   = 8 - REG_W;
    localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(IX_DEV0 >> REG_W);
    localparam logic [7:0] NUM_DEV_B = 8'(NUM_DEV);

    logic [7:0]       dev_sel;
    logic             in_win;
    logic             sel_ok;
    logic [REG_W-1:0] reg_off;
    logic [7:0]       dev_rd [NUM_DEV];

    assign in_win   = (idx_q[7:REG_W] == WIN_TAG);
    assign sel_ok   = (dev_sel < NUM_DEV_B);
    assign reg_off  = idx_q[REG_W-1:0];
    assign exit_req = dat_we && (idx_q == IX_EXIT) && (wdata == EXIT_CMD);

    // Index latch and device selector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= 8'h00;
            dev_sel <= 8'h00;
        end else begin
            if (idx_we) idx_q <= wdata;
            if (dat_we && idx_q == IX_DEVSEL) dev_sel <= wdata;
        end
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        logic [7:0] regs [DEV_REGS];

        // Store writes aimed at this device's window
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < DEV_REGS; r++) regs[r] <= 8'h00;
            end else if (dat_we && in_win && sel_ok && dev_sel[DEV_W-1:0] == DEV_W'(d)) begin
                regs[reg_off] <= wdata;
            end
        end

        assign dev_rd[d] = regs[reg_off];
    end

    // Data-port read multiplexer
    always_comb begin
        case (idx_q)
            IX_DEVSEL: dat_rdata = dev_sel;
            IX_ID_HI:  dat_rdata = CHIP_ID[15:8];
            IX_ID_LO:  dat_rdata = CHIP_ID[7:0];
            IX_REV:    dat_rdata = CHIP_REV;
            default:   dat_rdata = (in_win && sel_ok) ? dev_rd[dev_sel[DEV_W-1:0]] : 8'h00;
        endcase
    end

    AST_LOCKED_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(dev_sel)); // R5
    AST_LOCKED_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(idx_q)); // R6
endmodule

// File: rtl/cfg_key_gate.sv
// Module: cfg_key_gate (top)
// Decodes the strapped index/data port pair, routes locked index writes to
// the key matcher and unlocked traffic to the register bank.
// Assumes one bus access per cycle and a strap that is stable while in use.
module cfg_key_gate
    import cfg_gate_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter logic [ADDR_W-1:0]  BASE_LO  = ADDR_W'(16'h002E),
    parameter logic [ADDR_W-1:0]  BASE_HI  = ADDR_W'(16'h004E),
    parameter logic [15:0]        CHIP_ID  = 16'h8716,
    parameter logic [7:0]         CHIP_REV = 8'h02,
    parameter int                 NUM_DEV  = 4,
    parameter int                 DEV_REGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata
);
    logic [ADDR_W-1:0] base_addr;
    logic              idx_hit, dat_hit;
    logic              unlocked, exit_req;
    logic [7:0]        idx_q, dat_rdata;

    assign base_addr = base_sel ? BASE_HI : BASE_LO;
    assign idx_hit   = (io_addr == base_addr);
    assign dat_hit   = (io_addr == base_addr + ADDR_W'(1));

    cfg_key_match i_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_we   (io_wr && idx_hit && !unlocked),
        .key_byte (io_wdata),
        .key_last (base_sel ? KEY_LAST_H : KEY_LAST_L),
        .exit_req (exit_req),
        .unlocked (unlocked)
    );

    cfg_reg_bank #(
        .CHIP_ID  (CHIP_ID),
        .CHIP_REV (CHIP_REV),
        .NUM_DEV  (NUM_DEV),
        .DEV_REGS (DEV_REGS)
    ) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .unlocked  (unlocked),
        .idx_we    (io_wr && idx_hit && unlocked),
        .dat_we    (io_wr && dat_hit && unlocked),
        .wdata     (io_wdata),
        .idx_q     (idx_q),
        .dat_rdata (dat_rdata),
        .exit_req  (exit_req)
    );

    // Read-data selection: open ports only while unlocked
    always_comb begin
        if (unlocked && idx_hit)      io_rdata = idx_q;
        else if (unlocked && dat_hit) io_rdata = dat_rdata;
        else                          io_rdata = 8'hFF;
    end

    AST_LOCKED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && (idx_hit || dat_hit) && !unlocked) |-> (io_rdata == 8'hFF)); // R1
    AST_EXIT_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |-> unlocked); // R9
endmodule

// File: tb/test_cfg_key_gate.sv
module test_cfg_key_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_sel = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    int          n_checks = 0;
    int          n_errors = 0;
    logic [7:0]  rv;

    always #10 clk = ~clk;

    cfg_key_gate i_cfg_key_gate (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic key(input logic [15:0] base, input logic [7:0] last);
        wr(base, 8'h87); wr(base, 8'h01); wr(base, 8'h55); wr(base, last);
    endtask

    task automatic reg_rd(input logic [15:0] base, input logic [7:0] ix, output logic [7:0] d);
        wr(base, ix); rd(base + 16'd1, d);
    endtask

    task automatic reg_wr(input logic [15:0] base, input logic [7:0] ix, input logic [7:0] d);
        wr(base, ix); wr(base + 16'd1, d);
    endtask

    task automatic t_reset;
        rd(16'h2E, rv); check("R1 index port after reset", rv, 8'hFF);
        rd(16'h2F, rv); check("R1 data port after reset", rv, 8'hFF);
    endtask

    task automatic t_unlock_low;
        base_sel = 1'b0;
        key(16'h2E, 8'h55);
        wr(16'h2E, 8'h20);
        rd(16'h2E, rv); check("R2/R6 index readback after low-base key", rv, 8'h20);
        rd(16'h2F, rv); check("R7 ID high byte", rv, 8'h87);
        reg_rd(16'h2E, 8'h21, rv); check("R7 ID low byte", rv, 8'h16);
        reg_rd(16'h2E, 8'h22, rv); check("R7 revision", rv, 8'h02);
        reg_wr(16'h2E, 8'h20, 8'h00);
        reg_rd(16'h2E, 8'h20, rv); check("R7 ID is read-only", rv, 8'h87);
        rd(16'h4F, rv); check("R10 inactive data port reads FF", rv, 8'hFF);
        wr(16'h4E, 8'h07);
        rd(16'h2E, rv); check("R10 inactive index write ignored", rv, 8'h20);
    endtask

    task automatic t_relock;
        reg_wr(16'h2E, 8'h02, 8'h01);
        rd(16'h2E, rv); check("R9 other value keeps unlocked", rv, 8'h02);
        wr(16'h2F, 8'h02);
        rd(16'h2E, rv); check("R9 exit command locks index port", rv, 8'hFF);
        rd(16'h2F, rv); check("R9 exit command locks data port", rv, 8'hFF);
    endtask

    task automatic t_locked_writes;
        wr(16'h2E, 8'h07);
        wr(16'h2F, 8'h03);
        rd(16'h2F, rv); check("R5 locked data read", rv, 8'hFF);
        key(16'h2E, 8'h55);
        reg_rd(16'h2E, 8'h07, rv); check("R5 locked data write ignored", rv, 8'h00);
        reg_wr(16'h2E, 8'h02, 8'h02);
    endtask

    task automatic t_high_base;
        base_sel = 1'b0;
        key(16'h2E, 8'hAA);
        rd(16'h2E, rv); check("R3 AA on low base stays locked", rv, 8'hFF);
        base_sel = 1'b1;
        key(16'h4E, 8'h55);
        rd(16'h4E, rv); check("R3 55 on high base stays locked", rv, 8'hFF);
        key(16'h2E, 8'hAA);
        rd(16'h2E, rv); check("R10 key at inactive base ignored", rv, 8'hFF);
        rd(16'h4E, rv); check("R10 high base still locked", rv, 8'hFF);
        key(16'h4E, 8'hAA);
        reg_rd(16'h4E, 8'h20, rv); check("R3 unlock at high base, ID high", rv, 8'h87);
        reg_wr(16'h4E, 8'h02, 8'h02);
        rd(16'h4F, rv); check("R9 relock at high base", rv, 8'hFF);
        base_sel = 1'b0;
    endtask

    task automatic t_restart;
        wr(16'h2E, 8'h87); key(16'h2E, 8'h55);
        rd(16'h2E, rv); check("R4 doubled first byte unlocks", rv, 8'h02);
        reg_wr(16'h2E, 8'h02, 8'h02);
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h00);
        wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
        rd(16'h2E, rv); check("R4 wrong byte returns to idle", rv, 8'hFF);
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); key(16'h2E, 8'h55);
        rd(16'h2E, rv); check("R4 mid-key 0x87 restarts", rv, 8'h02);
    endtask

    task automatic t_devices;
        reg_wr(16'h2E, 8'h07, 8'h00); reg_wr(16'h2E, 8'h30, 8'hA5);
        reg_wr(16'h2E, 8'h07, 8'h01); reg_wr(16'h2E, 8'h30, 8'h3C);
        reg_rd(16'h2E, 8'h07, rv); check("R8 selector readback", rv, 8'h01);
        reg_rd(16'h2E, 8'h30, rv); check("R8 device 1 store", rv, 8'h3C);
        reg_wr(16'h2E, 8'h07, 8'h00);
        reg_rd(16'h2E, 8'h30, rv); check("R8 device 0 store kept", rv, 8'hA5);
        reg_wr(16'h2E, 8'h3F, 8'h5A);
        reg_rd(16'h2E, 8'h3F, rv); check("R8 last window register", rv, 8'h5A);
        reg_wr(16'h2E, 8'h07, 8'h09); reg_wr(16'h2E, 8'h31, 8'h77);
        reg_rd(16'h2E, 8'h31, rv); check("R8 absent device reads 00", rv, 8'h00);
        reg_wr(16'h2E, 8'h07, 8'h00);
        reg_rd(16'h2E, 8'h31, rv); check("R8 absent device write dropped", rv, 8'h00);
        reg_wr(16'h2E, 8'h02, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlock_low();
        t_relock();
        t_locked_writes();
        t_high_base();
        t_restart();
        t_devices();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule